// File: doc/BRIEF.md
# Read-Only Banked Cache With Bypass

This block is a mid-level read cache placed between several upstream clients and a larger downstream cache. It keeps no written data. A client write invalidates any copy of the addressed line and goes on to the downstream port unchanged. A read can carry a bypass flag. A bypassed read is served from the cache on a hit, and on a miss it fetches from downstream without allocating a line.

Storage is split into banks, and the two address bits just above the line offset select the bank. Each bank is 16-way set associative and uses its own downstream request/response port, so traffic to different banks proceeds in parallel. Within a set, a round-robin pointer picks the victim. Each bank accepts at most one request per cycle, and the lowest-numbered client wins a conflict. A bank holds one refill in flight. During that refill it still accepts writes, and a write that matches the pending line cancels its allocation.

All request channels are valid/ready. A client holds its request stable until it sees ready in the same cycle. `cl_req_ready` stays low while the target bank is claimed by a lower-numbered client, while a read finds its bank refilling, while a downstream request cannot be accepted, or while the client already has a read in flight. Responses to clients and from downstream are single-cycle pulses with no back-pressure.

Top module: `ro_bank_cache`

## Requirements
- R1: A request to byte address a is handled by bank a[3:2]. Any downstream request of bank b carries an address whose bits [3:2] equal b.
- R2: A read that hits returns the stored line data on `cl_rsp_valid` in the cycle right after acceptance and issues no downstream request.
- R3: A read miss issues a downstream read in its acceptance cycle. The downstream data is returned to the client in the cycle after `dn_rsp_valid`, and the line is allocated, so a repeat read hits.
- R4: A write is accepted only while the downstream port of its bank is ready. In that same cycle it appears downstream with its address and data. It produces no client response, and it invalidates a matching cached line, so the next read of that line misses.
- R5: A bypassed read that hits returns the cached data without a downstream request. A bypassed read that misses returns downstream data and allocates nothing.
- R6: A write to the line of an outstanding refill is accepted during the refill, including in the cycle the refill data arrives. The refill data still reaches the client, but the line is not allocated.
- R7: Victims in a set follow a per-set round-robin pointer starting at way 0. After 17 distinct lines fill one set, the first line is evicted and the second still hits.
- R8: A bank accepts one request per cycle. When two clients target the same bank, the lower-numbered client is accepted and the other sees ready low. Clients targeting different banks are accepted in the same cycle.
- R9: A bank with a refill in flight refuses reads until the refill returns, while other banks keep serving.
- R10: A client has at most one read in flight. Its ready stays low from the acceptance of a read until that read's response.
- R11: After reset no line is valid, and no client response or downstream request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl_req_valid | input | NC | Per-client request valid |
| cl_req_ready | output | NC | Per-client request accepted this cycle |
| cl_req_write | input | NC | 1 = write, 0 = read |
| cl_req_bypass | input | NC | Read without allocation |
| cl_req_addr | input | NC x AW | Byte address per client |
| cl_req_wdata | input | NC x DW | Write data per client |
| cl_rsp_valid | output | NC | Read data pulse per client |
| cl_rsp_data | output | NC x DW | Read data per client |
| dn_req_valid | output | NB | Downstream request valid per bank |
| dn_req_ready | input | NB | Downstream accepts request |
| dn_req_write | output | NB | Downstream request is a write |
| dn_req_addr | output | NB x AW | Downstream address |
| dn_req_wdata | output | NB x DW | Downstream write data |
| dn_rsp_valid | input | NB | Downstream read data pulse |
| dn_rsp_data | input | NB x DW | Downstream read data |

## Verification
The delicate coincidence is a refill arriving from downstream in the same cycle that a write to the pending line is accepted. Both events then try to act on the same line in that one cycle. The bench holds the downstream response and releases it one cycle before it presents the write, so both land on the same clock edge. The outcome is judged at the ports. The refilling client must receive the downstream data, and a later read of the line must go downstream again. A second pairing, two clients aiming at one bank in the same cycle, is judged by the ready pattern and both responses.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic {BK_IDLE, BK_WAIT} bank_st_e;
endpackage

// File: rtl/rbc_arb.sv
module rbc_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // lowest index wins: isolate least significant set bit
  assign gnt = req & ~(req - N'(1));
endmodule

// File: rtl/rbc_lookup.sv
module rbc_lookup #(
  parameter int WAYS  = 16,
  parameter int TAG_W = 10,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [WAYS-1:0]            row_vld,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = row_vld[w] && (row_tag[w] == tag);
  end

  always_comb begin
    way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) way = WAY_W'(w);
  end

  assign hit = |match;
endmodule

// File: rtl/rbc_bank.sv
module rbc_bank
  import rbc_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int OFF_W  = 2,
  parameter int BANK_W = 2,
  parameter int SET_W  = 2,
  parameter int WAYS   = 16,
  parameter int CID_W  = 1,
  localparam int SETS   = 1 << SET_W,
  localparam int TAG_LO = OFF_W + BANK_W + SET_W,
  localparam int TAG_W  = AW - TAG_LO,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_write,
  input  logic             in_bypass,
  input  logic [AW-1:0]    in_addr,
  input  logic [CID_W-1:0] in_cid,
  output logic             dn_req_valid,
  input  logic             dn_req_ready,
  output logic             dn_req_write,
  output logic [AW-1:0]    dn_req_addr,
  input  logic             dn_rsp_valid,
  input  logic [DW-1:0]    dn_rsp_data,
  output logic             rsp_valid,
  output logic [CID_W-1:0] rsp_cid,
  output logic [DW-1:0]    rsp_data
);
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tags_q;
  logic [SETS-1:0][WAYS-1:0][DW-1:0]    data_q;
  logic [SETS-1:0][WAYS-1:0]            vld_q;
  logic [SETS-1:0][WAY_W-1:0]           rr_q;

  bank_st_e         st_q;
  logic [SET_W-1:0] pend_set_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic [CID_W-1:0] pend_cid_q;
  logic             pend_noalloc_q;

  logic [SET_W-1:0] set_i;
  logic [TAG_W-1:0] tag_i;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic             acc, pend_match, wr_kill, fill, do_alloc;

  assign set_i = in_addr[OFF_W+BANK_W +: SET_W];
  assign tag_i = in_addr[AW-1:TAG_LO];

  rbc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_lookup (
    .row_tag (tags_q[set_i]),
    .row_vld (vld_q[set_i]),
    .tag     (tag_i),
    .hit     (hit),
    .way     (hit_way)
  );

  always_comb begin
    if (in_write) in_ready = dn_req_ready;
    else          in_ready = (st_q == BK_IDLE) && (hit || dn_req_ready);
    dn_req_valid = in_valid && (in_write || ((st_q == BK_IDLE) && !hit));
  end

  assign dn_req_write = in_write;
  assign dn_req_addr  = in_addr;

  assign acc        = in_valid && in_ready;
  assign pend_match = (st_q == BK_WAIT) && (set_i == pend_set_q) && (tag_i == pend_tag_q);
  assign wr_kill    = acc && in_write && pend_match;
  assign fill       = (st_q == BK_WAIT) && dn_rsp_valid;
  assign do_alloc   = fill && !pend_noalloc_q && !wr_kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q          <= '0;
      rr_q           <= '0;
      st_q           <= BK_IDLE;
      rsp_valid      <= 1'b0;
      rsp_cid        <= '0;
      rsp_data       <= '0;
      pend_set_q     <= '0;
      pend_tag_q     <= '0;
      pend_cid_q     <= '0;
      pend_noalloc_q <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (acc && !in_write) begin
        if (hit) begin
          rsp_valid <= 1'b1;
          rsp_cid   <= in_cid;
          rsp_data  <= data_q[set_i][hit_way];
        end else begin
          st_q           <= BK_WAIT;
          pend_set_q     <= set_i;
          pend_tag_q     <= tag_i;
          pend_cid_q     <= in_cid;
          pend_noalloc_q <= in_bypass;
        end
      end
      if (acc && in_write && hit) vld_q[set_i][hit_way] <= 1'b0;
      if (wr_kill) pend_noalloc_q <= 1'b1;
      if (fill) begin
        st_q      <= BK_IDLE;
        rsp_valid <= 1'b1;
        rsp_cid   <= pend_cid_q;
        rsp_data  <= dn_rsp_data;
      end
      if (do_alloc) begin
        vld_q[pend_set_q][rr_q[pend_set_q]] <= 1'b1;
        rr_q[pend_set_q] <= rr_q[pend_set_q] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      tags_q[pend_set_q][rr_q[pend_set_q]] <= pend_tag_q;
      data_q[pend_set_q][rr_q[pend_set_q]] <= dn_rsp_data;
    end
  end
endmodule

// File: rtl/ro_bank_cache.sv
module ro_bank_cache #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int NC     = 2,
  parameter int OFF_W  = 2,
  parameter int BANK_W = 2,
  parameter int SET_W  = 2,
  parameter int WAYS   = 16,
  localparam int NB    = 1 << BANK_W,
  localparam int CID_W = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NC-1:0]         cl_req_valid,
  output logic [NC-1:0]         cl_req_ready,
  input  logic [NC-1:0]         cl_req_write,
  input  logic [NC-1:0]         cl_req_bypass,
  input  logic [NC-1:0][AW-1:0] cl_req_addr,
  input  logic [NC-1:0][DW-1:0] cl_req_wdata,
  output logic [NC-1:0]         cl_rsp_valid,
  output logic [NC-1:0][DW-1:0] cl_rsp_data,
  output logic [NB-1:0]         dn_req_valid,
  input  logic [NB-1:0]         dn_req_ready,
  output logic [NB-1:0]         dn_req_write,
  output logic [NB-1:0][AW-1:0] dn_req_addr,
  output logic [NB-1:0][DW-1:0] dn_req_wdata,
  input  logic [NB-1:0]         dn_rsp_valid,
  input  logic [NB-1:0][DW-1:0] dn_rsp_data
);
  logic [NC-1:0]             busy_q;
  logic [NB-1:0][NC-1:0]     gnt;
  logic [NB-1:0]             b_valid, b_ready, b_write, b_bypass, b_rsp_valid;
  logic [NB-1:0][AW-1:0]     b_addr;
  logic [NB-1:0][CID_W-1:0]  b_cid, b_rsp_cid;
  logic [NB-1:0][DW-1:0]     b_rsp_data;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [NC-1:0] want;

    always_comb begin
      for (int c = 0; c < NC; c++)
        want[c] = cl_req_valid[c] && !busy_q[c] &&
                  (cl_req_addr[c][OFF_W +: BANK_W] == BANK_W'(b));
    end

    rbc_arb #(.N(NC)) i_arb (.req(want), .gnt(gnt[b]));

    always_comb begin
      b_write[b]      = 1'b0;
      b_bypass[b]     = 1'b0;
      b_addr[b]       = '0;
      b_cid[b]        = '0;
      dn_req_wdata[b] = '0;
      for (int c = 0; c < NC; c++)
        if (gnt[b][c]) begin
          b_write[b]      = cl_req_write[c];
          b_bypass[b]     = cl_req_bypass[c];
          b_addr[b]       = cl_req_addr[c];
          b_cid[b]        = CID_W'(c);
          dn_req_wdata[b] = cl_req_wdata[c];
        end
    end

    assign b_valid[b] = |gnt[b];

    rbc_bank #(
      .AW(AW), .DW(DW), .OFF_W(OFF_W), .BANK_W(BANK_W),
      .SET_W(SET_W), .WAYS(WAYS), .CID_W(CID_W)
    ) i_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (b_valid[b]),
      .in_ready     (b_ready[b]),
      .in_write     (b_write[b]),
      .in_bypass    (b_bypass[b]),
      .in_addr      (b_addr[b]),
      .in_cid       (b_cid[b]),
      .dn_req_valid (dn_req_valid[b]),
      .dn_req_ready (dn_req_ready[b]),
      .dn_req_write (dn_req_write[b]),
      .dn_req_addr  (dn_req_addr[b]),
      .dn_rsp_valid (dn_rsp_valid[b]),
      .dn_rsp_data  (dn_rsp_data[b]),
      .rsp_valid    (b_rsp_valid[b]),
      .rsp_cid      (b_rsp_cid[b]),
      .rsp_data     (b_rsp_data[b])
    );
  end

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      cl_req_ready[c] = 1'b0;
      cl_rsp_valid[c] = 1'b0;
      cl_rsp_data[c]  = '0;
      for (int b = 0; b < NB; b++) begin
        if (gnt[b][c] && b_ready[b]) cl_req_ready[c] = 1'b1;
        if (b_rsp_valid[b] && (b_rsp_cid[b] == CID_W'(c))) begin
          cl_rsp_valid[c] = 1'b1;
          cl_rsp_data[c]  = b_rsp_data[b];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else
      for (int c = 0; c < NC; c++) begin
        if (cl_req_valid[c] && cl_req_ready[c] && !cl_req_write[c]) busy_q[c] <= 1'b1;
        else if (cl_rsp_valid[c])                                 busy_q[c] <= 1'b0;
      end
  end
endmodule

// File: rtl/ro_bank_cache_chk.sv
module ro_bank_cache_chk #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int NC     = 2,
  parameter int OFF_W  = 2,
  parameter int BANK_W = 2,
  localparam int NB    = 1 << BANK_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NC-1:0]         cl_req_valid,
  input logic [NC-1:0]         cl_req_ready,
  input logic [NC-1:0]         cl_req_write,
  input logic [NC-1:0][AW-1:0] cl_req_addr,
  input logic [NC-1:0][DW-1:0] cl_req_wdata,
  input logic [NC-1:0]         cl_rsp_valid,
  input logic [NB-1:0]         dn_req_valid,
  input logic [NB-1:0]         dn_req_write,
  input logic [NB-1:0][AW-1:0] dn_req_addr,
  input logic [NB-1:0][DW-1:0] dn_req_wdata
);
  logic [NC-1:0] open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= '0;
    else
      for (int c = 0; c < NC; c++) begin
        if (cl_req_valid[c] && cl_req_ready[c] && !cl_req_write[c]) open_q[c] <= 1'b1;
        else if (cl_rsp_valid[c])                                 open_q[c] <= 1'b0;
      end
  end

  for (genvar b = 0; b < NB; b++) begin : g_b
    // R1
    bank_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req_valid[b] |-> (dn_req_addr[b][OFF_W +: BANK_W] == BANK_W'(b)));
  end

  for (genvar c = 0; c < NC; c++) begin : g_c
    logic [BANK_W-1:0] cb;
    logic              wr_acc;
    assign cb     = cl_req_addr[c][OFF_W +: BANK_W];
    assign wr_acc = cl_req_valid[c] && cl_req_ready[c] && cl_req_write[c];

    // R10
    rsp_has_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cl_rsp_valid[c] |-> open_q[c]);
    // R10
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_req_valid[c] && cl_req_ready[c] && !cl_req_write[c]) |-> !open_q[c]);
    // R4
    write_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |-> (dn_req_valid[cb] && dn_req_write[cb] &&
                  dn_req_addr[cb] == cl_req_addr[c] && dn_req_wdata[cb] == cl_req_wdata[c]));
    // R4
    write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && !open_q[c]) |=> !cl_rsp_valid[c]);

    for (genvar d = c + 1; d < NC; d++) begin : g_d
      // R8
      bank_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_req_valid[c] && cl_req_ready[c] && cl_req_valid[d] && cl_req_ready[d]) |->
        (cl_req_addr[c][OFF_W +: BANK_W] != cl_req_addr[d][OFF_W +: BANK_W]));
    end
  end
endmodule

bind ro_bank_cache ro_bank_cache_chk #(
  .AW(AW), .DW(DW), .NC(NC), .OFF_W(OFF_W), .BANK_W(BANK_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cl_req_valid (cl_req_valid),
  .cl_req_ready (cl_req_ready),
  .cl_req_write (cl_req_write),
  .cl_req_addr  (cl_req_addr),
  .cl_req_wdata (cl_req_wdata),
  .cl_rsp_valid (cl_rsp_valid),
  .dn_req_valid (dn_req_valid),
  .dn_req_write (dn_req_write),
  .dn_req_addr  (dn_req_addr),
  .dn_req_wdata (dn_req_wdata)
);

// File: tb/test_ro_bank_cache.sv
module test_ro_bank_cache;
  localparam int AW = 16, DW = 32, NC = 2, NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NC-1:0]         cl_req_valid = '0, cl_req_write = '0, cl_req_bypass = '0;
  logic [NC-1:0][AW-1:0] cl_req_addr = '0;
  logic [NC-1:0][DW-1:0] cl_req_wdata = '0;
  logic [NC-1:0]         cl_req_ready, cl_rsp_valid;
  logic [NC-1:0][DW-1:0] cl_rsp_data;
  logic [NB-1:0]         dn_req_valid, dn_req_write;
  logic [NB-1:0][AW-1:0] dn_req_addr;
  logic [NB-1:0][DW-1:0] dn_req_wdata;
  logic [NB-1:0]         dn_req_ready = '1;
  logic [NB-1:0]         dn_rsp_valid;
  logic [NB-1:0][DW-1:0] dn_rsp_data;

  ro_bank_cache i_ro_bank_cache (.*);

  // downstream model
  logic [DW-1:0] salt = 32'h1000_0001;
  logic [NB-1:0] hold = '0;
  logic [NB-1:0] pend;
  logic [NB-1:0][AW-1:0] paddr;
  int rd_cnt [NB];
  int wr_cnt [NB];
  logic [AW-1:0] last_wa;
  logic [DW-1:0] last_wd;

  function automatic logic [DW-1:0] fdat(logic [AW-1:0] a, logic [DW-1:0] s);
    return {a, a ^ 16'h5A5A} ^ s;
  endfunction

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rst_n) begin
        pend[b] <= 1'b0; dn_rsp_valid[b] <= 1'b0; dn_rsp_data[b] <= '0;
        rd_cnt[b] <= 0; wr_cnt[b] <= 0;
      end else begin
        dn_rsp_valid[b] <= 1'b0;
        if (pend[b] && !hold[b]) begin
          dn_rsp_valid[b] <= 1'b1;
          dn_rsp_data[b]  <= fdat(paddr[b], salt);
          pend[b]         <= 1'b0;
        end
        if (dn_req_valid[b] && dn_req_ready[b]) begin
          if (dn_req_write[b]) begin
            wr_cnt[b] <= wr_cnt[b] + 1; last_wa <= dn_req_addr[b]; last_wd <= dn_req_wdata[b];
          end else begin
            rd_cnt[b] <= rd_cnt[b] + 1; pend[b] <= 1'b1; paddr[b] <= dn_req_addr[b];
          end
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int rds(int b);
    return rd_cnt[b];
  endfunction

  // drive at negedge, return at the negedge after acceptance
  task automatic send(int c, bit wr, bit byp, logic [AW-1:0] a, logic [DW-1:0] wd);
    cl_req_valid[c] = 1'b1; cl_req_write[c] = wr; cl_req_bypass[c] = byp;
    cl_req_addr[c] = a; cl_req_wdata[c] = wd;
    for (int n = 0; n < 60; n++) begin
      #1;
      if (cl_req_ready[c]) begin
        @(negedge clk);
        cl_req_valid[c] = 1'b0;
        return;
      end
      @(negedge clk);
    end
    cl_req_valid[c] = 1'b0;
    chk(0, "send timeout", 0, 1);
  endtask

  task automatic wait_rsp(int c, output logic [DW-1:0] d, output int cyc);
    cyc = 0;
    while (!cl_rsp_valid[c] && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    d = cl_rsp_data[c];
    if (cl_rsp_valid[c]) @(negedge clk);
  endtask

  task automatic rd(int c, bit byp, logic [AW-1:0] a, output logic [DW-1:0] d, output int cyc);
    send(c, 1'b0, byp, a, '0);
    wait_rsp(c, d, cyc);
  endtask

  localparam logic [AW-1:0] A = 16'h0008, B = 16'h0104, C = 16'h0200, D = 16'h0210;

  task automatic t_reset_state();
    logic [DW-1:0] d; int cyc, r0;
    chk(cl_rsp_valid == '0, "R11 rsp idle", 32'(cl_rsp_valid), 0);
    chk(dn_req_valid == '0, "R11 dn idle", 32'(dn_req_valid), 0);
    r0 = rds(3);
    rd(0, 0, 16'h000C, d, cyc);
    chk(rds(3) == r0 + 1, "R11 empty after reset", rds(3), r0 + 1);
  endtask

  task automatic t_miss_then_hit();
    logic [DW-1:0] d, s0; int cyc; int r[NB];
    for (int b = 0; b < NB; b++) r[b] = rds(b);
    s0 = salt;
    rd(0, 0, A, d, cyc);
    chk(rds(2) == r[2] + 1 && rds(0) == r[0] && rds(1) == r[1] && rds(3) == r[3],
        "R1 bank select", rds(2), r[2] + 1);
    chk(d == fdat(A, s0), "R3 miss data", d, fdat(A, s0));
    salt = salt + 32'h0101_0101;
    rd(1, 0, A, d, cyc);
    chk(d == fdat(A, s0), "R2 hit data", d, fdat(A, s0));
    chk(cyc == 0 && rds(2) == r[2] + 1, "R2 hit latency no downstream", cyc, 0);
  endtask

  task automatic t_write_invalidate();
    logic [DW-1:0] d; int cyc, w0, r0;
    w0 = wr_cnt[2]; r0 = rds(2);
    dn_req_ready[2] = 1'b0;
    cl_req_valid[1] = 1'b1; cl_req_write[1] = 1'b1; cl_req_addr[1] = A; cl_req_wdata[1] = 32'hCAFE_0001;
    #1;
    chk(!cl_req_ready[1], "R4 write back-pressure", cl_req_ready[1], 0);
    @(negedge clk);
    dn_req_ready[2] = 1'b1;
    #1;
    chk(cl_req_ready[1], "R4 write accepted", cl_req_ready[1], 1);
    @(negedge clk);
    cl_req_valid[1] = 1'b0;
    chk(!cl_rsp_valid[1], "R4 no response", cl_rsp_valid[1], 0);
    chk(wr_cnt[2] == w0 + 1 && last_wa == A && last_wd == 32'hCAFE_0001,
        "R4 forwarded", last_wd, 32'hCAFE_0001);
    salt = salt ^ 32'h00FF_0000;
    rd(0, 0, A, d, cyc);
    chk(d == fdat(A, salt) && rds(2) == r0 + 1, "R4 line invalidated", d, fdat(A, salt));
  endtask

  task automatic t_bypass();
    logic [DW-1:0] d, s0; int cyc, r0;
    r0 = rds(1);
    rd(0, 1, B, d, cyc);
    chk(d == fdat(B, salt) && rds(1) == r0 + 1, "R5 bypass miss data", d, fdat(B, salt));
    rd(0, 0, B, d, cyc);
    chk(rds(1) == r0 + 2, "R5 bypass miss no allocation", rds(1), r0 + 2);
    s0 = salt;
    salt = salt + 32'h0000_0333;
    rd(1, 1, B, d, cyc);
    chk(d == fdat(B, s0) && rds(1) == r0 + 2, "R5 bypass hit cached", d, fdat(B, s0));
  endtask

  task automatic t_refill_write();
    logic [DW-1:0] d; int cyc, r0;
    hold[0] = 1'b1;
    send(0, 0, 0, C, '0);
    send(1, 1, 0, C, 32'h1234_5678);
    chk(last_wa == C, "R6 write during refill", last_wa, C);
    hold[0] = 1'b0;
    wait_rsp(0, d, cyc);
    chk(d == fdat(C, salt), "R6 refill data returned", d, fdat(C, salt));
    r0 = rds(0);
    rd(0, 0, C, d, cyc);
    chk(rds(0) == r0 + 1, "R6 refill not allocated", rds(0), r0 + 1);
    // write lands in the same cycle the refill data arrives
    hold[0] = 1'b1;
    send(0, 0, 0, D, '0);
    hold[0] = 1'b0;
    @(negedge clk);
    cl_req_valid[1] = 1'b1; cl_req_write[1] = 1'b1; cl_req_addr[1] = D; cl_req_wdata[1] = 32'h0BAD_F00D;
    #1;
    chk(cl_req_ready[1] && dn_rsp_valid[0], "R6 same-cycle setup", cl_req_ready[1], 1);
    @(negedge clk);
    cl_req_valid[1] = 1'b0;
    chk(cl_rsp_valid[0] && cl_rsp_data[0] == fdat(D, salt), "R6 same-cycle data",
        cl_rsp_data[0], fdat(D, salt));
    @(negedge clk);
    r0 = rds(0);
    rd(0, 0, D, d, cyc);
    chk(rds(0) == r0 + 1, "R6 same-cycle not allocated", rds(0), r0 + 1);
  endtask

  task automatic t_round_robin();
    logic [DW-1:0] d; int cyc, r0;
    for (int k = 0; k < 17; k++) rd(0, 0, 16'(16'h003C + k * 64), d, cyc);
    r0 = rds(3);
    rd(0, 0, 16'h007C, d, cyc);
    chk(rds(3) == r0, "R7 second line kept", rds(3), r0);
    rd(0, 0, 16'h003C, d, cyc);
    chk(rds(3) == r0 + 1, "R7 first line evicted", rds(3), r0 + 1);
  endtask

  task automatic t_bank_conflict();
    logic [DW-1:0] d, e0, e1; int cyc;
    rd(0, 0, 16'h0014, d, cyc); e0 = d;
    rd(0, 0, 16'h0024, d, cyc); e1 = d;
    cl_req_valid = 2'b11; cl_req_write = '0; cl_req_bypass = '0;
    cl_req_addr[0] = 16'h0014; cl_req_addr[1] = 16'h0024;
    #1;
    chk(cl_req_ready == 2'b01, "R8 lower client wins", 32'(cl_req_ready), 1);
    @(negedge clk);
    cl_req_valid[0] = 1'b0;
    chk(cl_rsp_valid[0] && cl_rsp_data[0] == e0, "R8 winner data", cl_rsp_data[0], e0);
    #1;
    chk(cl_req_ready[1], "R8 loser next cycle", cl_req_ready[1], 1);
    @(negedge clk);
    cl_req_valid[1] = 1'b0;
    chk(cl_rsp_valid[1] && cl_rsp_data[1] == e1, "R8 loser data", cl_rsp_data[1], e1);
    @(negedge clk);
    cl_req_valid = 2'b11; cl_req_addr[0] = 16'h0014; cl_req_addr[1] = A;
    #1;
    chk(cl_req_ready == 2'b11, "R8 different banks parallel", 32'(cl_req_ready), 3);
    @(negedge clk);
    cl_req_valid = '0;
    chk(cl_rsp_valid == 2'b11, "R8 both respond", 32'(cl_rsp_valid), 3);
    @(negedge clk);
  endtask

  task automatic t_bank_busy();
    logic [DW-1:0] d; int cyc, r2;
    hold[0] = 1'b1;
    send(0, 0, 0, 16'h0220, '0);
    cl_req_valid[1] = 1'b1; cl_req_write[1] = 1'b0; cl_req_addr[1] = 16'h0230;
    #1;
    chk(!cl_req_ready[1], "R9 refilling bank refuses read", cl_req_ready[1], 0);
    @(negedge clk);
    cl_req_valid[1] = 1'b0;
    r2 = rds(2);
    rd(1, 0, A, d, cyc);
    chk(cyc == 0 && rds(2) == r2, "R9 other bank serves", cyc, 0);
    hold[0] = 1'b0;
    wait_rsp(0, d, cyc);
    chk(d == fdat(16'h0220, salt), "R9 refill completes", d, fdat(16'h0220, salt));
  endtask

  task automatic t_one_outstanding();
    logic [DW-1:0] d; int cyc;
    hold[0] = 1'b1;
    send(0, 0, 0, 16'h0240, '0);
    cl_req_valid[0] = 1'b1; cl_req_write[0] = 1'b0; cl_req_addr[0] = A;
    #1;
    chk(!cl_req_ready[0], "R10 second read blocked", cl_req_ready[0], 0);
    @(negedge clk);
    cl_req_valid[0] = 1'b0;
    hold[0] = 1'b0;
    wait_rsp(0, d, cyc);
    rd(0, 0, A, d, cyc);
    chk(cyc == 0, "R10 read after response", cyc, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_miss_then_hit();
    t_write_invalidate();
    t_bypass();
    t_refill_write();
    t_round_robin();
    t_bank_conflict();
    t_bank_busy();
    t_one_outstanding();
    done = 1;
    report();
  end
endmodule